// File: doc/BRIEF.md
# Multiplexed Address/Data Parallel Port Master

This block is the bus master for a processor's external parallel port. A single group of sixteen pins carries both the address and the data of each access. An address phase drives the address and raises the address strobe, so that a latch on the board can hold it. The data phase that follows carries write data or receives read data. The read and write strobes are active low. The port takes requests with a 24-bit address and returns read data with a one-clock valid pulse.

Configuration selects one of three modes:
- **16-bit mode.** Every access begins with an address phase.
- **8-bit mode.** The address phase is skipped when the upper address field matches the one the external latch already holds. The low address byte then travels on the upper pins during the data phase.
- **Flag mode.** The pins are given over to general-purpose use. No bus cycles are issued and every strobe rests at its inactive level.

The polarity of the address strobe can also be configured.

A request is offered with `req_valid` and is taken on a clock edge where `req_ready` is high. `req_ready` is high only while the port is idle and not in flag mode. Configuration is expected to change only while the port is idle, except for strobe polarity, which acts at once.

Top module: `pport_mux_bus`

## Requirements
- R1: While reset is applied, and afterwards until a request is taken, the pin output enable is 0. `rd_n` and `wr_n` are 1, and `ale_o` sits at its inactive level, which is low with `cfg_ale_low`=0. `req_ready` is 1 outside flag mode.
- R2: In 16-bit mode (`cfg_wide`=1) a taken request produces this sequence, starting the clock after acceptance:
  - one address clock with the strobe active, the output enable at 1 and `pad_out` = address bits 15..0;
  - one turnaround clock with the enable at 0 and all strobes inactive;
  - the data phase.
- R3: In 8-bit mode (`cfg_wide`=0) the address clock drives `pad_out` = address bits 23..8. When the upper field equals the value stored at the previous 8-bit address phase, the address and turnaround clocks are skipped and the data phase starts the clock after acceptance.
- R4: The stored upper field is invalid after reset and after any change of `cfg_wide` or `cfg_flag_mode`. The next 8-bit access therefore always has an address phase.
- R5: In every data clock of a write, `wr_n` is 0, `rd_n` is 1 and the output enable is 1. `pad_out` is the 16-bit write data in 16-bit mode. In 8-bit mode it is {address bits 7..0, write data bits 7..0}. The same value stays driven through the release clock.
- R6: During a read the output enable is 0 and `rd_n` is 0 in every data clock. `pad_in` is sampled at the end of the last data clock. `rsp_valid` is 1 for exactly the release clock, with `rsp_rdata` = `pad_in`, or {8'h00, `pad_in`[7:0]} in 8-bit mode.
- R7: The data phase lasts `cfg_wait`+1 clocks, using the value present at acceptance.
- R8: With `cfg_ale_low`=1 the address strobe is inverted: low while asserted and high at rest.
- R9: While `cfg_flag_mode`=1, `req_ready` is 0, no request is taken, the output enable is 0 and all strobes stay inactive.
- R10: A request held on `req_valid` while a cycle is in progress is not taken until the port is idle again. `req_ready` is 0 from the clock after acceptance until the port is idle.
- R11: Each cycle ends with one release clock in which all strobes are inactive. The port is idle and ready in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wide | input | 1 | 1 = 16-bit data mode, 0 = 8-bit data mode |
| cfg_flag_mode | input | 1 | 1 = pins used as general-purpose flags, bus parked |
| cfg_ale_low | input | 1 | 1 = address strobe active low |
| cfg_wait | input | 4 | Extra data-phase clocks beyond the first |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Port idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data (low byte used in 8-bit mode) |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | 16 | Returned read data |
| pad_in | input | 16 | Value seen on the shared pins |
| pad_out | output | 16 | Value driven onto the shared pins |
| pad_oe | output | 1 | Output enable of the shared pins |
| ale_o | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Two functions can land on the same clock edge:
- **Mode change with acceptance.** Invalidating the stored upper field can coincide with accepting an 8-bit request. The bench changes `cfg_wide` on the very edge at which a request is taken, and a following access with the same upper field must still skip its address phase, because the accepted request latched a fresh value.
- **Stalled request at the release edge.** A request held through a busy cycle is accepted exactly one clock after the release clock. The behavioural reference predicts that clock independently.

Every clock, the reference compares all pins, the strobes, the ready signal and the read return.

// File: rtl/pport_pkg.sv
// Shared types for the multiplexed parallel port.
// Assumes: one bus phase is active per clock.
package pport_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_TURN = 3'd2,
        PH_DATA = 3'd3,
        PH_REL  = 3'd4
    } pport_phase_e;

endpackage

// File: rtl/pport_upper_track.sv
// Remembers the upper address field last presented to the external latch.
// Decides whether the access being offered needs an address phase.
// Assumes: a load happens only at acceptance of an 8-bit access.
module pport_upper_track #(
    parameter int UP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wide,
    input  logic            flag_mode,
    input  logic            accept,
    input  logic [UP_W-1:0] req_upper,
    output logic            need_ale
);

    logic            valid_q;
    logic [UP_W-1:0] upper_q;
    logic            prev_wide_q;
    logic            prev_flag_q;
    logic            mode_chg;
    logic            load;

    // Detect a mode change against the previous clock's configuration.
    always_comb begin
        mode_chg = (cfg_wide != prev_wide_q) || (flag_mode != prev_flag_q);
        load     = accept && !cfg_wide;
        need_ale = cfg_wide || !valid_q || mode_chg || (req_upper != upper_q);
    end

    // Hold the stored upper field and its validity; a fresh load wins over invalidation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q     <= 1'b0;
            upper_q     <= '0;
            prev_wide_q <= 1'b0;
            prev_flag_q <= 1'b0;
        end else begin
            prev_wide_q <= cfg_wide;
            prev_flag_q <= flag_mode;
            if (load) begin
                valid_q <= 1'b1;
                upper_q <= req_upper;
            end else if (mode_chg) begin
                valid_q <= 1'b0;
            end
        end
    end

    // R4: after a mode change with no load, the next offered access needs an address phase.
    assert_mode_change_forces_ale_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mode_chg && !load) |=> need_ale);

endmodule

// File: rtl/pport_seq.sv
// Bus phase sequencer: address, turnaround, data with wait clocks, release.
// Latches the request at acceptance.
// Assumes: cfg_wait and cfg_wide are only meaningful at acceptance.
module pport_seq
    import pport_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_mode,
    input  logic              cfg_wide,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              need_ale,
    output logic              req_ready,
    output logic              accept,
    output pport_phase_e      phase,
    output logic              last_data,
    output logic              txn_write,
    output logic              txn_wide,
    output logic [ADDR_W-1:0] txn_addr,
    output logic [DATA_W-1:0] txn_wdata
);

    logic [WAIT_W-1:0] cnt_q;

    // Ready and acceptance depend only on the idle phase and flag mode.
    always_comb begin
        req_ready = (phase == PH_IDLE) && !flag_mode;
        accept    = req_ready && req_valid;
        last_data = (phase == PH_DATA) && (cnt_q == '0);
    end

    // Advance through the bus phases; flag mode parks the port at idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt_q     <= '0;
            txn_write <= 1'b0;
            txn_wide  <= 1'b0;
            txn_addr  <= '0;
            txn_wdata <= '0;
        end else if (flag_mode) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        txn_write <= req_write;
                        txn_wide  <= cfg_wide;
                        txn_addr  <= req_addr;
                        txn_wdata <= req_wdata;
                        cnt_q     <= cfg_wait;
                        phase     <= need_ale ? PH_ADDR : PH_DATA;
                    end
                end
                PH_ADDR: phase <= PH_TURN;
                PH_TURN: phase <= PH_DATA;
                PH_DATA: begin
                    if (cnt_q == '0) phase <= PH_REL;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2: a 16-bit access always opens with an address phase.
    assert_wide_emits_ale_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (accept && cfg_wide) |=> (phase == PH_ADDR));

    // R10: the port reports busy right after it takes a request.
    assert_busy_after_accept_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R9: flag mode leaves the sequencer parked at idle.
    assert_flag_parks_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        flag_mode |=> (phase == PH_IDLE));

endmodule

// File: rtl/pport_pins.sv
// Pin driver: maps the bus phase onto the shared pins, the output enable and the strobes.
// Captures read data at the last data clock.
// Assumes: DATA_W is even and the upper address field is DATA_W bits wide.
module pport_pins
    import pport_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pport_phase_e      phase,
    input  logic              last_data,
    input  logic              txn_write,
    input  logic              txn_wide,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [DATA_W-1:0] txn_wdata,
    input  logic              ale_low,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] pad_out,
    output logic              pad_oe,
    output logic              ale_o,
    output logic              rd_n,
    output logic              wr_n,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int LO_W = DATA_W / 2;

    logic [DATA_W-1:0] addr_word;
    logic [DATA_W-1:0] data_word;
    logic              in_data;

    // Select the pin word for the address and data phases.
    always_comb begin
        addr_word = txn_wide ? txn_addr[DATA_W-1:0] : txn_addr[ADDR_W-1 -: DATA_W];
        data_word = txn_wide ? txn_wdata : {txn_addr[LO_W-1:0], txn_wdata[LO_W-1:0]};
        in_data   = (phase == PH_DATA);
    end

    // Drive the pins, the enable and the strobes from the current phase.
    always_comb begin
        ale_o   = (phase == PH_ADDR) ^ ale_low;
        rd_n    = !(in_data && !txn_write);
        wr_n    = !(in_data && txn_write);
        pad_oe  = 1'b0;
        pad_out = '0;
        case (phase)
            PH_ADDR: begin
                pad_oe  = 1'b1;
                pad_out = addr_word;
            end
            PH_DATA, PH_REL: begin
                pad_oe  = txn_write;
                pad_out = txn_write ? data_word : '0;
            end
            default: ;
        endcase
    end

    // Capture read data at the end of the last data clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= last_data && !txn_write;
            if (last_data && !txn_write)
                rsp_rdata <= txn_wide ? pad_in : {{LO_W{1'b0}}, pad_in[LO_W-1:0]};
        end
    end

    // R6: read data is returned as a single-clock pulse.
    assert_rsp_pulse_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2: the clock after an address phase is a quiet turnaround.
    assert_ale_then_quiet_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (phase == PH_ADDR) |=> (rd_n && wr_n && !pad_oe));

    // R5: read and write strobes are never active together.
    assert_strobes_exclusive_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

endmodule

// File: rtl/pport_mux_bus.sv
// Top of the multiplexed address/data parallel port master.
// Assumes: configuration other than strobe polarity changes only while idle.
module pport_mux_bus
    import pport_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              cfg_flag_mode,
    input  logic              cfg_ale_low,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] pad_out,
    output logic              pad_oe,
    output logic              ale_o,
    output logic              rd_n,
    output logic              wr_n
);

    localparam int UP_W = ADDR_W - DATA_W / 2;

    logic              accept;
    logic              need_ale;
    logic              last_data;
    logic              txn_write;
    logic              txn_wide;
    logic [ADDR_W-1:0] txn_addr;
    logic [DATA_W-1:0] txn_wdata;
    pport_phase_e      phase;

    pport_upper_track #(.UP_W(UP_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wide  (cfg_wide),
        .flag_mode (cfg_flag_mode),
        .accept    (accept),
        .req_upper (req_addr[ADDR_W-1 -: UP_W]),
        .need_ale  (need_ale)
    );

    pport_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_mode (cfg_flag_mode),
        .cfg_wide  (cfg_wide),
        .cfg_wait  (cfg_wait),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .need_ale  (need_ale),
        .req_ready (req_ready),
        .accept    (accept),
        .phase     (phase),
        .last_data (last_data),
        .txn_write (txn_write),
        .txn_wide  (txn_wide),
        .txn_addr  (txn_addr),
        .txn_wdata (txn_wdata)
    );

    pport_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .last_data (last_data),
        .txn_write (txn_write),
        .txn_wide  (txn_wide),
        .txn_addr  (txn_addr),
        .txn_wdata (txn_wdata),
        .ale_low   (cfg_ale_low),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .ale_o     (ale_o),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: tb/pport_mux_bus_tb_top.sv
// Cycle-by-cycle bench: a behavioural model queues the expected pin state per clock.
// The model is compared at every falling edge.
module pport_mux_bus_tb_top;

    typedef struct packed {
        logic        ale;
        logic        rd;
        logic        wr;
        logic        oe;
        logic [15:0] pout;
        logic        rv;
        logic [15:0] rdat;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b1, cfg_flag_mode = 1'b0, cfg_ale_low = 1'b0;
    logic [3:0]  cfg_wait = 4'd0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0, pad_in = '0;
    logic        req_ready, rsp_valid, pad_oe, ale_o, rd_n, wr_n;
    logic [15:0] rsp_rdata, pad_out;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    exp_t q[$];
    string tq[$];

    // Settings applied at the next step.
    logic       n_rst = 1'b0, n_wide = 1'b1, n_flag = 1'b0, n_alelow = 1'b0;
    logic [3:0] n_wait = 4'd0;

    // Model of the stored upper field.
    logic        m_valid = 1'b0;
    logic [15:0] m_upper = '0;
    logic        m_pw = 1'b0, m_pf = 1'b0;

    pport_mux_bus dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_flag_mode(cfg_flag_mode),
        .cfg_ale_low(cfg_ale_low), .cfg_wait(cfg_wait), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .ale_o(ale_o),
        .rd_n(rd_n), .wr_n(wr_n)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] pin_pat(input int n);
        logic [31:0] t;
        t = n * 40503 + 12345;
        return t[15:0] ^ 16'h6c3a;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Compare every output against the expectation for the current clock.
    task automatic compare(input exp_t e, input string tg, input logic exp_rdy);
        logic bad;
        bad = 1'b0;
        n_cmp++;
        if (ale_o !== (e.ale ^ cfg_ale_low)) begin
            bad = 1'b1;
            $display("FAIL %s ale_o: actual=%b expected=%b (cyc %0d)", tg, ale_o, e.ale ^ cfg_ale_low, cyc);
        end
        if (rd_n !== e.rd || wr_n !== e.wr) begin
            bad = 1'b1;
            $display("FAIL %s rd_n/wr_n: actual=%b%b expected=%b%b (cyc %0d)", tg, rd_n, wr_n, e.rd, e.wr, cyc);
        end
        if (pad_oe !== e.oe || (e.oe && pad_out !== e.pout)) begin
            bad = 1'b1;
            $display("FAIL %s pins: actual=%b/%h expected=%b/%h (cyc %0d)", tg, pad_oe, pad_out, e.oe, e.pout, cyc);
        end
        if (rsp_valid !== e.rv || (e.rv && rsp_rdata !== e.rdat)) begin
            bad = 1'b1;
            $display("FAIL %s rsp: actual=%b/%h expected=%b/%h (cyc %0d)", tg, rsp_valid, rsp_rdata, e.rv, e.rdat, cyc);
        end
        if (req_ready !== exp_rdy) begin
            bad = 1'b1;
            $display("FAIL %s req_ready: actual=%b expected=%b (cyc %0d)", tg, req_ready, exp_rdy, cyc);
        end
        if (bad) n_bad++;
    endtask

    // One clock: check outputs, drive inputs for the next edge, update the model.
    task automatic step(input logic v, input logic w, input logic [23:0] a,
                        input logic [15:0] d, output logic acc);
        exp_t  cur;
        string tg;
        logic  idle_now, mc, need;
        int    len;
        exp_t  e;
        @(negedge clk);
        if (q.size() > 0) begin
            cur = q.pop_front(); tg = tq.pop_front(); idle_now = 1'b0;
        end else begin
            cur = '{ale:1'b0, rd:1'b1, wr:1'b1, oe:1'b0, pout:16'h0, rv:1'b0, rdat:16'h0};
            tg = !rst_n ? "R1" : (cfg_flag_mode ? "R9" : "R1");
            idle_now = 1'b1;
        end
        if (cyc > 0) compare(cur, tg, idle_now && !cfg_flag_mode);
        rst_n = n_rst; cfg_wide = n_wide; cfg_flag_mode = n_flag;
        cfg_ale_low = n_alelow; cfg_wait = n_wait;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        pad_in = pin_pat(cyc);
        acc = idle_now && !n_flag && v && n_rst;
        if (!n_rst) begin
            m_valid = 1'b0; m_pw = 1'b0; m_pf = 1'b0;
        end else begin
            mc   = (n_wide != m_pw) || (n_flag != m_pf);
            need = n_wide || !m_valid || mc || (a[23:8] != m_upper);
            if (acc) begin
                // Address and turnaround clocks (R2, R3)
                if (need) begin
                    e = '{ale:1'b1, rd:1'b1, wr:1'b1, oe:1'b1,
                          pout:(n_wide ? a[15:0] : a[23:8]), rv:1'b0, rdat:16'h0};
                    q.push_back(e); tq.push_back(n_wide ? "R2" : "R3");
                    e = '{ale:1'b0, rd:1'b1, wr:1'b1, oe:1'b0, pout:16'h0, rv:1'b0, rdat:16'h0};
                    q.push_back(e); tq.push_back("R2");
                end
                // Data clocks, cfg_wait+1 of them (R5, R6, R7)
                for (int i = 0; i <= int'(n_wait); i++) begin
                    e = '{ale:1'b0, rd:w, wr:!w, oe:w,
                          pout:(n_wide ? d : {a[7:0], d[7:0]}), rv:1'b0, rdat:16'h0};
                    q.push_back(e); tq.push_back(w ? "R5" : "R7");
                end
                // Release clock with read return (R11, R6)
                len = q.size() + 1;
                e = '{ale:1'b0, rd:1'b1, wr:1'b1, oe:w,
                      pout:(n_wide ? d : {a[7:0], d[7:0]}), rv:!w,
                      rdat:(n_wide ? pin_pat(cyc + len - 1) : {8'h00, pin_pat(cyc + len - 1)[7:0]})};
                q.push_back(e); tq.push_back(w ? "R11" : "R6");
            end
            if (acc && !n_wide) begin
                m_valid = 1'b1; m_upper = a[23:8];
            end else if (mc) begin
                m_valid = 1'b0;
            end
            m_pw = n_wide; m_pf = n_flag;
        end
    endtask

    // Hold a request until it is taken (stall checks R10), then drop it.
    task automatic issue(input logic w, input logic [23:0] a, input logic [15:0] d);
        logic acc;
        acc = 1'b0;
        while (!acc) step(1'b1, w, a, d, acc);
    endtask

    task automatic idle(input int n);
        logic acc;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 24'h0, 16'h0, acc);
    endtask

    initial begin
        logic acc;
        // R1: reset state, then idle after release
        idle(3);
        n_rst = 1'b1;
        idle(3);
        // R2, R5, R7: 16-bit write with no wait; R6: read with two wait clocks
        issue(1'b1, 24'hA1B2C3, 16'h5AA5);
        n_wait = 4'd2;
        // R10: back-to-back read held while the write runs
        issue(1'b0, 24'h00F00D, 16'h0);
        issue(1'b1, 24'h000123, 16'hFFFF);
        idle(6);
        // R3, R4: switch to 8-bit; first access emits the address, the second skips it
        n_wide = 1'b0; n_wait = 4'd0;
        issue(1'b1, 24'h123456, 16'h00C7);
        issue(1'b0, 24'h1234AA, 16'h0);
        issue(1'b1, 24'h124400, 16'h0011);
        idle(6);
        // R4: leave and re-enter 8-bit mode with the same upper field, address phase again
        n_wide = 1'b1; idle(2); n_wide = 1'b0;
        issue(1'b0, 24'h124401, 16'h0);
        idle(6);
        // R4: mode change on the acceptance edge, followed by a skip on the same upper field
        n_wide = 1'b1; idle(2);
        n_wide = 1'b0;
        step(1'b1, 1'b1, 24'h777701, 16'h0042, acc);
        idle(6);
        issue(1'b1, 24'h777702, 16'h0043);
        idle(6);
        // R8: active-low strobe, both idle level and assertion
        n_alelow = 1'b1; n_wide = 1'b1;
        idle(2);
        issue(1'b1, 24'h00BEEF, 16'h1357);
        idle(6);
        n_alelow = 1'b0;
        // R9: flag mode refuses requests and keeps strobes inactive
        n_flag = 1'b1;
        idle(2);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 24'h123456, 16'h9999, acc);
        n_flag = 1'b0; n_wide = 1'b0;
        idle(2);
        // R4: the flag-mode round trip invalidated the stored field
        issue(1'b0, 24'h124402, 16'h0);
        idle(6);
        // R7: longest wait count
        n_wait = 4'd15; n_wide = 1'b1;
        issue(1'b0, 24'h00CAFE, 16'h0);
        idle(20);
        // Mixed traffic
        for (int i = 0; i < 60; i++) begin
            logic [23:0] a;
            a = {(($urandom % 2) ? 16'h1234 : 16'hBEEF), 8'($urandom)};
            n_wait = 4'($urandom % 4);
            if ($urandom % 6 == 0) n_wide = ~n_wide;
            if ($urandom % 8 == 0) n_alelow = ~n_alelow;
            issue(1'($urandom % 2), a, 16'($urandom));
            if ($urandom % 2 == 0) idle(1);
        end
        idle(30);
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

endmodule